// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital control for a dual-slope integrating measurement. It steps an analog front end through four phases in a fixed order. The phases are offset nulling (auto-zero), signal integration over a fixed window, reference de-integration, and integrator discharge. Each phase has one one-hot enable line. During de-integration the block counts clocks until the comparator reports that the integrator has crossed zero. That count, together with the sign latched at the end of integration, is the reading.

With the run request held high the block free-runs. Every measurement cycle then has exactly the same length, because auto-zero takes up whatever time the other phases leave over. Dropping the request lets the current cycle finish, and the block then parks in auto-zero with the last reading held. From that parked state, a rising edge of the request starts a new cycle after a short, fixed auto-zero lead-in. A reading that hits the count ceiling is flagged as over-range and stretches the discharge phase. A small reading is flagged as under-range.

Top module: `dsc_seq`

## Requirements
- R1: `phase_en` is always one-hot, with bit 0 auto-zero (also driven while parked), bit 1 integrate, bit 2 de-integrate and bit 3 discharge. A measurement always runs auto-zero, integrate, de-integrate, discharge in that order.
- R2: Integration lasts exactly INT_CLKS clocks. On its last clock `cmp_pos` is latched into `ref_flip`, which stays constant through de-integration. `res_neg` of the resulting reading is the inverse of that latched value.
- R3: De-integration ends on the first clock on which `cmp_pos` differs from `ref_flip`. Calling that clock k (counted from 0), the phase lasts k+1 clocks and `res_count` becomes k.
- R4: If no crossing is seen within FULL_SCALE+1 de-integration clocks, the phase ends after exactly that many clocks. `res_count` then becomes FULL_SCALE+1 and `res_over` is set. A crossing on the last allowed clock still counts as an in-range reading.
- R5: `res_under` is set exactly when the reading is in range and below UNDER_LIMIT.
- R6: Discharge lasts ZI_NORM clocks after an in-range reading and ZI_OVR clocks after an over-range reading.
- R7: While `run_req` stays high, integrate phases start exactly CYCLE_CLKS clocks apart.
- R8: If `run_req` is low when a cycle ends, the block parks in auto-zero with no further phases and no `done`, and the reading is held.
- R9: While parked, a rising edge of `run_req`, even one clock long, starts integration START_AZ+3 clocks after the first clock edge that sees the request high. That is two synchroniser flops, one edge-detect cycle, then START_AZ clocks of auto-zero.
- R10: A pulse on `run_req` during a running cycle that ends before the cycle does has no effect: the block still parks afterwards.
- R11: `busy` is high exactly during integrate and de-integrate. `done` is a one-clock pulse, high on the first discharge clock, with all result outputs already updated.
- R12: After reset the block is parked: `phase_en` = 0001, and `busy`, `done`, `ref_flip` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_pos | input | 1 | Comparator: integrator output above zero |
| run_req | input | 1 | Run request: high free-runs, rising edge starts from parked |
| phase_en | output | 4 | One-hot phase enables (AZ, INT, DE, ZI from bit 0) |
| busy | output | 1 | High during integrate and de-integrate |
| ref_flip | output | 1 | Latched sign, selects reference polarity for de-integration |
| res_count | output | $clog2(FULL_SCALE+2) | Clock count of the last reading |
| res_neg | output | 1 | Last reading negative |
| res_over | output | 1 | Last reading over-range |
| res_under | output | 1 | Last reading under-range |
| done | output | 1 | One-clock pulse when a reading completes |

## Verification
The bench builds the block with a 20-clock integration window, a full scale of 40 counts, an under-range floor of 4, discharge lengths of 3 and 12, an 80-clock cycle and a 5-clock start lead-in. At that scale every reading from 0 to past the over-range ceiling can be swept, for both signs. This covers each boundary: zero, the under-range floor, the last in-range count and the forced ceiling. The short cycle also lets the bench time every phase length, the fixed cycle period, and the parking and restart sequences clock by clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    ST_PARK,
    ST_AZ,
    ST_INT,
    ST_DE,
    ST_ZI
  } dsc_state_e;

  // Discharge length picked by the over-range outcome of the last reading.
  function automatic int unsigned zi_span(input logic over,
                                          input int unsigned norm_len,
                                          input int unsigned long_len);
    return over ? long_len : norm_len;
  endfunction

  // In-range readings below the floor are flagged as under-range.
  function automatic logic below_floor(input int unsigned cnt,
                                       input int unsigned floor_val,
                                       input logic over);
    return !over && (cnt < floor_val);
  endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/dsc_phase_ctl.sv
module dsc_phase_ctl
  import dsc_pkg::*;
#(
  parameter int INT_CLKS   = 10000,
  parameter int OVR_LIMIT  = 20001,
  parameter int ZI_NORM    = 150,
  parameter int ZI_OVR     = 6200,
  parameter int CYCLE_CLKS = 40002,
  parameter int START_AZ   = 100,
  parameter int CW         = 16,
  parameter int RW         = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_pos,
  input  logic          run_lvl,
  input  logic          run_rise,
  output dsc_state_e    st,
  output logic          flag,
  output logic          de_end,
  output logic [RW-1:0] de_count,
  output logic          de_over
);
  localparam logic [CW-1:0] CYC_LAST = CW'(CYCLE_CLKS - 1);
  localparam logic [CW-1:0] CYC_LEAD = CW'(CYCLE_CLKS - START_AZ);
  localparam logic [CW-1:0] INT_LAST = CW'(INT_CLKS - 1);
  localparam logic [CW-1:0] DE_LAST  = CW'(OVR_LIMIT - 1);

  logic [CW-1:0] cyc;
  logic [CW-1:0] pcnt;
  logic          armed;
  logic          last_over;

  // Named events for the checks below.
  logic de_hit, de_full, int_last, zi_last, cyc_end;
  logic [CW-1:0] zi_end_cnt;

  assign de_hit     = (st == ST_DE) && (cmp_pos != flag);
  assign de_full    = (st == ST_DE) && (pcnt == DE_LAST);
  assign int_last   = (st == ST_INT) && (pcnt == INT_LAST);
  assign zi_end_cnt = CW'(zi_span(last_over, ZI_NORM, ZI_OVR) - 1);
  assign zi_last    = (st == ST_ZI) && (pcnt == zi_end_cnt);
  assign cyc_end    = (st == ST_AZ) && (cyc == CYC_LAST);

  assign de_end   = de_hit || de_full;
  assign de_over  = !de_hit;
  assign de_count = de_hit ? RW'(pcnt) : RW'(OVR_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PARK;
      cyc       <= '0;
      pcnt      <= '0;
      armed     <= 1'b0;
      flag      <= 1'b0;
      last_over <= 1'b0;
    end else begin
      case (st)
        ST_PARK: begin
          if (run_rise) begin
            st    <= ST_AZ;
            cyc   <= CYC_LEAD;
            armed <= 1'b1;
          end
        end
        ST_AZ: begin
          if (cyc_end) begin
            if (run_lvl || armed) begin
              st    <= ST_INT;
              cyc   <= '0;
              pcnt  <= '0;
              armed <= 1'b0;
            end else begin
              st <= ST_PARK;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        ST_INT: begin
          cyc <= cyc + 1'b1;
          if (int_last) begin
            flag <= cmp_pos;
            st   <= ST_DE;
            pcnt <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_DE: begin
          cyc <= cyc + 1'b1;
          if (de_end) begin
            st        <= ST_ZI;
            pcnt      <= '0;
            last_over <= de_over;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_ZI: begin
          cyc <= cyc + 1'b1;
          if (zi_last) st <= ST_AZ;
          else         pcnt <= pcnt + 1'b1;
        end
        default: st <= ST_PARK;
      endcase
    end
  end

  // R2: the latched sign does not move while de-integrating
  assert_flag_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DE && $past(st) == ST_DE) |-> $stable(flag));

  // R8: parked stays parked without a request edge
  assert_park_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARK && !run_rise) |=> st == ST_PARK);

  // R6: discharge never runs past its long length
  assert_zi_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ZI) |-> (pcnt < CW'(ZI_OVR)));

  // R7: a free-running cycle end leads straight into integration
  assert_wrap_to_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && run_lvl) |=> st == ST_INT);
endmodule

// File: rtl/dsc_result.sv
module dsc_result
  import dsc_pkg::*;
#(
  parameter int RW          = 15,
  parameter int OVR_LIMIT   = 20001,
  parameter int UNDER_LIMIT = 1800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_end,
  input  logic [RW-1:0] de_count,
  input  logic          de_over,
  input  logic          flag,
  output logic [RW-1:0] res_count,
  output logic          res_neg,
  output logic          res_over,
  output logic          res_under,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_count <= '0;
      res_neg   <= 1'b0;
      res_over  <= 1'b0;
      res_under <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= de_end;
      if (de_end) begin
        res_count <= de_count;
        res_neg   <= ~flag;
        res_over  <= de_over;
        res_under <= below_floor(32'(de_count), UNDER_LIMIT, de_over);
      end
    end
  end

  // R4: an over-range reading always carries the ceiling count
  assert_over_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_over |-> (res_count == RW'(OVR_LIMIT)));

  // R5: under-range and over-range never coexist
  assert_under_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_under |-> !res_over);

  // R11: done is a single-clock pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
  import dsc_pkg::*;
#(
  parameter int INT_CLKS    = 10000,
  parameter int FULL_SCALE  = 20000,
  parameter int UNDER_LIMIT = 1800,
  parameter int ZI_NORM     = 150,
  parameter int ZI_OVR      = 6200,
  parameter int CYCLE_CLKS  = 40002,
  parameter int START_AZ    = 100,
  parameter int SYNC_STAGES = 2,
  localparam int OVR_LIMIT  = FULL_SCALE + 1,
  localparam int CW         = $clog2(CYCLE_CLKS),
  localparam int RW         = $clog2(OVR_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_pos,
  input  logic          run_req,
  output logic [3:0]    phase_en,
  output logic          busy,
  output logic          ref_flip,
  output logic [RW-1:0] res_count,
  output logic          res_neg,
  output logic          res_over,
  output logic          res_under,
  output logic          done
);
  logic          run_lvl, run_rise;
  dsc_state_e    st;
  logic          flag, de_end, de_over;
  logic [RW-1:0] de_count;

  dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(run_req), .level(run_lvl), .rise(run_rise)
  );

  dsc_phase_ctl #(
    .INT_CLKS(INT_CLKS), .OVR_LIMIT(OVR_LIMIT), .ZI_NORM(ZI_NORM),
    .ZI_OVR(ZI_OVR), .CYCLE_CLKS(CYCLE_CLKS), .START_AZ(START_AZ),
    .CW(CW), .RW(RW)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmp_pos(cmp_pos), .run_lvl(run_lvl),
    .run_rise(run_rise), .st(st), .flag(flag), .de_end(de_end),
    .de_count(de_count), .de_over(de_over)
  );

  dsc_result #(.RW(RW), .OVR_LIMIT(OVR_LIMIT), .UNDER_LIMIT(UNDER_LIMIT)) u_res (
    .clk(clk), .rst_n(rst_n), .de_end(de_end), .de_count(de_count),
    .de_over(de_over), .flag(flag), .res_count(res_count), .res_neg(res_neg),
    .res_over(res_over), .res_under(res_under), .done(done)
  );

  always_comb begin
    phase_en = 4'b0000;
    case (st)
      ST_PARK, ST_AZ: phase_en[0] = 1'b1;
      ST_INT:         phase_en[1] = 1'b1;
      ST_DE:          phase_en[2] = 1'b1;
      ST_ZI:          phase_en[3] = 1'b1;
      default:        phase_en = 4'b0000;
    endcase
  end

  assign busy     = (st == ST_INT) || (st == ST_DE);
  assign ref_flip = flag;

  // R1: exactly one phase enable at any time
  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_en) == 1);

  // R1: de-integration is only ever entered from integration
  assert_de_after_int_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_en[2]) |-> $past(phase_en[1]));

  // R11: a reading completes exactly as discharge begins
  assert_done_at_zi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase_en[3]);
endmodule

// File: tb/test_dsc_seq.sv
`timescale 1ns/1ps
module test_dsc_seq;
  localparam int INT_CLKS = 20, FULL = 40, UNDER = 4, ZIN = 3, ZIO = 12;
  localparam int CYCLE = 80, SAZ = 5, OVR = FULL + 1;

  logic clk = 1'b0, rst_n = 1'b0, cmp_pos = 1'b0, run_req = 1'b0;
  logic [3:0] phase_en;
  logic busy, ref_flip, res_neg, res_over, res_under, done;
  logic [5:0] res_count;

  int total = 0, bad = 0, cyc_ctr = 0;
  int tgt_n = 0, de_k = 0, last_int = 0;
  bit tgt_s = 1'b1, have_last = 1'b0, finished = 1'b0;

  dsc_seq #(.INT_CLKS(INT_CLKS), .FULL_SCALE(FULL), .UNDER_LIMIT(UNDER),
            .ZI_NORM(ZIN), .ZI_OVR(ZIO), .CYCLE_CLKS(CYCLE), .START_AZ(SAZ))
    i_dsc_seq (.clk(clk), .rst_n(rst_n), .cmp_pos(cmp_pos), .run_req(run_req),
      .phase_en(phase_en), .busy(busy), .ref_flip(ref_flip), .res_count(res_count),
      .res_neg(res_neg), .res_over(res_over), .res_under(res_under), .done(done));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc_ctr++;

  // Behavioural comparator: keeps the input sign, flips after tgt_n de-integrate clocks.
  always @(negedge clk) begin
    if (phase_en[2]) begin
      cmp_pos = (de_k >= tgt_n) ? ~tgt_s : tgt_s;
      de_k++;
    end else begin
      de_k = 0;
      cmp_pos = tgt_s;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic conv(input int n, input bit s, input bit drop);
    int il, dl, zl, bb, t0, exp_cnt;
    bit exp_over;
    while (!phase_en[0]) @(negedge clk);
    tgt_n = n; tgt_s = s;
    while (!phase_en[1]) @(negedge clk);
    t0 = cyc_ctr;
    if (have_last) check(t0 - last_int == CYCLE, "R7 cycle period", t0 - last_int, CYCLE);
    last_int = t0; have_last = 1'b1;
    if (drop) run_req = 1'b0;
    il = 0; bb = 0;
    while (phase_en[1]) begin
      il++;
      if (!busy || phase_en != 4'b0010) bb++;
      @(negedge clk);
    end
    check(il == INT_CLKS, "R2 integrate length", il, INT_CLKS);
    check(phase_en == 4'b0100, "R1 integrate followed by de-integrate", phase_en, 4);
    dl = 0;
    while (phase_en[2]) begin
      dl++;
      if (!busy || ref_flip != s || phase_en != 4'b0100) bb++;
      @(negedge clk);
    end
    exp_over = (n >= OVR);
    exp_cnt  = exp_over ? OVR : n;
    check(dl == (exp_over ? OVR : n + 1), "R3 de-integrate length", dl, exp_over ? OVR : n + 1);
    check(phase_en == 4'b1000, "R1 de-integrate followed by discharge", phase_en, 8);
    check(done == 1'b1, "R11 done on first discharge clock", done, 1);
    check(res_count == exp_cnt, "R3 R4 reading", res_count, exp_cnt);
    check(res_over == exp_over, "R4 over-range flag", res_over, exp_over);
    check(res_under == (!exp_over && n < UNDER), "R5 under-range flag", res_under,
          !exp_over && n < UNDER);
    check(res_neg == !s, "R2 sign of reading", res_neg, !s);
    check(busy == 1'b0 && bb == 0, "R11 R1 busy and enables during conversion", bb, 0);
    zl = 0; bb = 0;
    while (phase_en[3]) begin
      zl++;
      if (zl > 1 && done) bb++;
      @(negedge clk);
    end
    check(zl == (exp_over ? ZIO : ZIN), "R6 discharge length", zl, exp_over ? ZIO : ZIN);
    check(bb == 0 && phase_en == 4'b0001, "R11 done single pulse, then auto-zero", bb, 0);
  endtask

  task automatic quiet(input int clocks, input string what, input int keep);
    int ints = 0, dones = 0;
    repeat (clocks) begin
      @(negedge clk);
      if (phase_en[1]) ints++;
      if (done) dones++;
    end
    check(ints == 0 && dones == 0, what, ints + dones, 0);
    check(res_count == keep && phase_en == 4'b0001, "R8 reading held while parked",
          res_count, keep);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(phase_en == 4'b0001, "R12 reset phase", phase_en, 1);
    check({busy, done, ref_flip, res_neg, res_over, res_under} == 6'b0, "R12 reset flags",
          {busy, done, ref_flip, res_neg, res_over, res_under}, 0);
    check(res_count == 0, "R12 reset reading", res_count, 0);

    // Sweep all readings across the range for both signs, free-running
    run_req = 1'b1;
    for (int s = 1; s >= 0; s--)
      for (int k = 0; k <= OVR + 3; k++) conv(k, s[0], 1'b0);

    // R8: drop the request mid-cycle; the cycle finishes, then the block parks
    conv(7, 1'b1, 1'b1);
    have_last = 1'b0;
    quiet(3 * CYCLE, "R8 no activity while parked", 7);

    // R9: one-clock pulse from parked starts after SAZ+3 clocks
    tgt_n = 25; tgt_s = 1'b0;
    run_req = 1'b1;
    @(negedge clk);
    n = 1;
    run_req = 1'b0;
    while (!phase_en[1]) begin @(negedge clk); n++; end
    check(n == SAZ + 3, "R9 restart latency", n, SAZ + 3);
    // R10: pulse during the running cycle is ignored
    run_req = 1'b1;
    repeat (2) @(negedge clk);
    run_req = 1'b0;
    while (!done) @(negedge clk);
    check(res_count == 25 && res_neg == 1'b1, "R9 reading after restart", res_count, 25);
    quiet(2 * CYCLE, "R10 mid-cycle pulse ignored", 25);

    // Restart and stay free-running through over-range readings
    run_req = 1'b1;
    conv(OVR + 5, 1'b1, 1'b0);
    conv(OVR - 1, 1'b0, 1'b0);
    conv(UNDER, 1'b1, 1'b0);
    summary();
  end

  initial begin
    wait (cyc_ctr == 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc_ctr, 0);
    summary();
  end
endmodule